// File: doc/BRIEF.md
# Dual-Register Output Logic Cell

This block is one output cell of a small programmable logic fabric. It takes two sum-term signals from the array, holds two independent state bits and drives one bidirectional pad through separate output, enable and input signals. Both state bits always return to the array, so either one can serve as buried state while the pad is used for other logic, or is only an input.

Each register has static configuration inputs. One selects D or T behaviour. The other selects whether the register is clocked by its own clock term or by the clock pin shared by all cells. Each register also has its own asynchronous clear term. A synchronous preset line, common to every cell, loads ones. A preload path used for test writes the pad level into whichever register the select input names. All clock sources are sampled against one fast system clock. A register acts only in the cycle in which its chosen source is seen rising.

The pad is driven from one of four sources: a combinatorial or registered path, fed by either the first sum term alone or both sum terms ORed together. A polarity bit can invert the result.

Top module: `dual_reg_macrocell`

## Requirements
- R1: After `rst_n` is released, both feedback bits read 0. In a registered output mode, `pin_o` then equals `out_inv`.
- R2: A register in D mode (`t_mode` bit 0) loads its data input in the system-clock cycle in which its selected clock source rises. Register 1's data is `sum_t[1]`. Register 0's data is given in R9.
- R3: A register in T mode (`t_mode` bit 1) inverts its state on a rising clock source when its data is 1, and holds its state when its data is 0.
- R4: `pclk_sel[i]`=0 clocks register i from `clk_t[i]`, and `pclk_sel[i]`=1 clocks it from `pin_clk`. The unselected source has no effect.
- R5: A register changes only in the cycle in which its source rises. While the source stays high, or while it falls, the register holds its state even if its data changes.
- R6: When `arst_t[i]` is 1, `fb[i]` reads 0 in the same cycle. The register stays 0 after release until its next clock rise. The clear wins over preset and preload.
- R7: When `sync_preset` is 1 at a clock rise, the register loads 1 instead of its D or T next state.
- R8: `fb[1:0]` always shows both registers, whatever the output mode, the enable term or the polarity.
- R9: `out_mode` bit 1 chooses the pad source: 1 for register 0, 0 for combinatorial. Bit 0 chooses the sum terms: 1 for `sum_t[0]|sum_t[1]`, 0 for `sum_t[0]` alone. The same choice sets register 0's data input.
- R10: `pin_o` is the selected source XOR `out_inv`.
- R11: `pin_oe` equals `oe_t` except during preload, when it is 0. `pin_fb` always follows `pin_i`.
- R12: With `preload_en`=1, a register's clock rise loads `pin_i` into register 0 when `preload_sel`=0, or into register 1 when it is 1. The pad level is stored as it is, whatever `out_inv` says. The unselected register holds its state, and preset is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low global reset |
| sum_t | input | 2 | Sum-term inputs for register 0 and register 1 |
| clk_t | input | 2 | Per-register clock terms |
| arst_t | input | 2 | Per-register asynchronous clear terms |
| t_mode | input | 2 | Per-register mode: 1 = T, 0 = D |
| pclk_sel | input | 2 | Per-register clock source: 1 = pin clock |
| pin_clk | input | 1 | Shared clock pin |
| sync_preset | input | 1 | Shared synchronous preset |
| out_mode | input | 2 | Bit 1 registered, bit 0 combined terms |
| out_inv | input | 1 | Output polarity inversion |
| oe_t | input | 1 | Output enable term |
| preload_en | input | 1 | Test preload mode |
| preload_sel | input | 1 | Preload target register |
| pin_i | input | 1 | Level seen at the pad |
| pin_o | output | 1 | Value driven to the pad |
| pin_oe | output | 1 | Pad driver enable |
| pin_fb | output | 1 | Pad input path back to the array |
| fb | output | 2 | Register feedback to the array |

## Verification
The properties assume that every clock source and control term is synchronous to `clk`. They also assume that each high and low phase of a clock source lasts at least one `clk` cycle, so that a rise is never missed. The mode and select bits are assumed not to move in the cycle in which they would create a false rise. The stimulus changes inputs only on the falling edge of `clk`, sets configuration before it pulses a source, and holds every pulse high for a full cycle and low for a full cycle.

// File: rtl/dual_reg_macrocell.sv
module dual_reg_macrocell (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sum_t,
  input  logic [1:0] clk_t,
  input  logic [1:0] arst_t,
  input  logic [1:0] t_mode,
  input  logic [1:0] pclk_sel,
  input  logic       pin_clk,
  input  logic       sync_preset,
  input  logic [1:0] out_mode,
  input  logic       out_inv,
  input  logic       oe_t,
  input  logic       preload_en,
  input  logic       preload_sel,
  input  logic       pin_i,
  output logic       pin_o,
  output logic       pin_oe,
  output logic       pin_fb,
  output logic [1:0] fb
);

  logic       comb_src;
  logic [1:0] d_in;

  assign comb_src = out_mode[0] ? (sum_t[0] | sum_t[1]) : sum_t[0];
  assign d_in[0]  = comb_src;
  assign d_in[1]  = sum_t[1];

  for (genvar i = 0; i < 2; i++) begin : g_reg
    logic q_r, prev_r, src, rise, nxt, mine;

    assign src  = pclk_sel[i] ? pin_clk : clk_t[i];
    assign rise = src & ~prev_r;
    assign mine = ((i == 1) == preload_sel);

    always_comb begin
      nxt = q_r;
      if (rise) begin
        if (preload_en)       nxt = mine ? pin_i : q_r;
        else if (sync_preset) nxt = 1'b1;
        else if (t_mode[i])   nxt = q_r ^ d_in[i];
        else                  nxt = d_in[i];
      end
      if (arst_t[i]) nxt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_r    <= 1'b0;
        prev_r <= 1'b1;
      end else begin
        q_r    <= nxt;
        prev_r <= src;
      end
    end

    assign fb[i] = q_r & ~arst_t[i];
  end

  assign pin_o  = (out_mode[1] ? fb[0] : comb_src) ^ out_inv;
  assign pin_oe = oe_t & ~preload_en;
  assign pin_fb = pin_i;

endmodule

// File: rtl/macrocell_checks.sv
module macrocell_checks (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] sum_t,
  input logic [1:0] clk_t,
  input logic [1:0] arst_t,
  input logic [1:0] t_mode,
  input logic [1:0] pclk_sel,
  input logic       pin_clk,
  input logic       sync_preset,
  input logic [1:0] out_mode,
  input logic       out_inv,
  input logic       preload_en,
  input logic [1:0] fb,
  input logic       pin_o
);
  logic [1:0] seen, src, up;
  assign src[0] = pclk_sel[0] ? pin_clk : clk_t[0];
  assign src[1] = pclk_sel[1] ? pin_clk : clk_t[1];
  assign up = src & ~seen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 2'b11;
    else        seen <= src;

  AST_HOLD_NO_RISE_A: assert property (@(posedge clk) disable iff (!rst_n)
    !up[0] && !arst_t[0] |=> arst_t[0] || $stable(fb[0])); // R5
  AST_HOLD_NO_RISE_B: assert property (@(posedge clk) disable iff (!rst_n)
    !up[1] && !arst_t[1] |=> arst_t[1] || $stable(fb[1])); // R5
  AST_CLEAR_A: assert property (@(posedge clk) disable iff (!rst_n)
    arst_t[0] |=> !fb[0]); // R6
  AST_CLEAR_B: assert property (@(posedge clk) disable iff (!rst_n)
    arst_t[1] |=> !fb[1]); // R6
  AST_PRESET_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    up[1] && sync_preset && !preload_en && !arst_t[1] |=> arst_t[1] || fb[1]); // R7
  AST_D_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    up[1] && !t_mode[1] && !sync_preset && !preload_en && !arst_t[1]
    |=> arst_t[1] || fb[1] == $past(sum_t[1])); // R2
  AST_T_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    up[1] && t_mode[1] && sum_t[1] && !sync_preset && !preload_en && !arst_t[1]
    |=> arst_t[1] || fb[1] != $past(fb[1])); // R3
  AST_REG_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_mode[1] |-> pin_o == (fb[0] ^ out_inv)); // R9
endmodule

bind dual_reg_macrocell macrocell_checks u_chk (
  .clk(clk), .rst_n(rst_n), .sum_t(sum_t), .clk_t(clk_t), .arst_t(arst_t),
  .t_mode(t_mode), .pclk_sel(pclk_sel), .pin_clk(pin_clk),
  .sync_preset(sync_preset), .out_mode(out_mode), .out_inv(out_inv),
  .preload_en(preload_en), .fb(fb), .pin_o(pin_o));

// File: tb/sim_dual_reg_macrocell.sv
`timescale 1ns/1ps
module sim_dual_reg_macrocell;
  logic clk = 0, rst_n = 0;
  logic [1:0] sum_t = 0, clk_t = 0, arst_t = 0, t_mode = 0, pclk_sel = 0, out_mode = 0;
  logic pin_clk = 0, sync_preset = 0, out_inv = 0, oe_t = 0;
  logic preload_en = 0, preload_sel = 0, pin_i = 0;
  logic pin_o, pin_oe, pin_fb;
  logic [1:0] fb;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_reg_macrocell u0 (.clk(clk), .rst_n(rst_n), .sum_t(sum_t), .clk_t(clk_t),
    .arst_t(arst_t), .t_mode(t_mode), .pclk_sel(pclk_sel), .pin_clk(pin_clk),
    .sync_preset(sync_preset), .out_mode(out_mode), .out_inv(out_inv), .oe_t(oe_t),
    .preload_en(preload_en), .preload_sel(preload_sel), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe(pin_oe), .pin_fb(pin_fb), .fb(fb));

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic pulse_term(int i);
    clk_t[i] = 1; step(); clk_t[i] = 0; step();
  endtask

  task automatic pulse_pin();
    pin_clk = 1; step(); pin_clk = 0; step();
  endtask

  task automatic clear_both();
    arst_t = 2'b11; step(); arst_t = 0; step();
  endtask

  task automatic t_reset();
    out_mode = 2'b10; out_inv = 0; #1;
    chk("R1 fb0", fb[0], 0); chk("R1 fb1", fb[1], 0); chk("R1 pin", pin_o, 0);
    out_inv = 1; #1; chk("R1 pin inv", pin_o, 1);
    out_inv = 0; out_mode = 0; step();
  endtask

  task automatic t_dmode();
    sum_t[1] = 1; pulse_term(1); chk("R2 load1", fb[1], 1);
    sum_t[1] = 0; pulse_term(1); chk("R2 load0", fb[1], 0);
    sum_t[1] = 1; pulse_pin(); chk("R4 pin ignored", fb[1], 0);
    sum_t[1] = 0;
  endtask

  task automatic t_level();
    sum_t[1] = 1; clk_t[1] = 1; step(); chk("R5 rise", fb[1], 1);
    sum_t[1] = 0; step(); step(); chk("R5 held high", fb[1], 1);
    clk_t[1] = 0; step(); chk("R5 fall", fb[1], 1);
    pulse_term(1); chk("R2 next rise", fb[1], 0);
  endtask

  task automatic t_toggle();
    t_mode[0] = 1; sum_t[0] = 1;
    pulse_term(0); chk("R3 flip up", fb[0], 1);
    pulse_term(0); chk("R3 flip down", fb[0], 0);
    pulse_term(0); sum_t[0] = 0;
    pulse_term(0); chk("R3 hold", fb[0], 1);
    t_mode[0] = 0; clear_both();
  endtask

  task automatic t_pinclk();
    pclk_sel[0] = 1; sum_t[0] = 1;
    pulse_term(0); chk("R4 term ignored", fb[0], 0);
    pulse_pin(); chk("R4 pin clock", fb[0], 1);
    pclk_sel[0] = 0; sum_t[0] = 0; clear_both();
  endtask

  task automatic t_preset();
    pclk_sel = 2'b11; t_mode[1] = 1; sync_preset = 1;
    pulse_pin(); chk("R7 d preset", fb[0], 1); chk("R7 t preset", fb[1], 1);
    sync_preset = 0; pclk_sel = 0; t_mode = 0;
  endtask

  task automatic t_clear();
    arst_t[0] = 1; #1; chk("R6 immediate", fb[0], 0);
    step(); arst_t[0] = 0; #1; chk("R6 stays 0", fb[0], 0);
    step();
    sync_preset = 1; clk_t[0] = 1; arst_t[0] = 1; step();
    arst_t[0] = 0; clk_t[0] = 0; sync_preset = 0; step();
    chk("R6 beats preset", fb[0], 0);
    chk("R8 other kept", fb[1], 1);
    clear_both();
  endtask

  task automatic t_outmodes();
    sum_t = 2'b10; out_inv = 0;
    out_mode = 2'b00; #1; chk("R9 comb sep", pin_o, 0);
    out_mode = 2'b01; #1; chk("R9 comb comb", pin_o, 1);
    out_inv = 1; #1; chk("R10 inverted", pin_o, 0);
    out_inv = 0; step();
    out_mode = 2'b10; pulse_term(0); chk("R9 reg sep", pin_o, 0);
    out_mode = 2'b11; pulse_term(0); chk("R9 reg comb", pin_o, 1);
    out_inv = 1; #1; chk("R10 reg inv", pin_o, 0);
    out_inv = 0; sum_t = 0; out_mode = 0; clear_both();
  endtask

  task automatic t_oe();
    oe_t = 1; #1; chk("R11 oe on", pin_oe, 1);
    oe_t = 0; #1; chk("R11 oe off", pin_oe, 0);
    oe_t = 1; preload_en = 1; #1; chk("R11 preload off", pin_oe, 0);
    preload_en = 0; oe_t = 0;
    pin_i = 1; #1; chk("R11 input path", pin_fb, 1);
    pin_i = 0; #1; chk("R11 input path 0", pin_fb, 0);
    step();
  endtask

  task automatic t_buried();
    out_mode = 0; oe_t = 0; sum_t = 2'b11;
    pulse_term(0); pulse_term(1);
    chk("R8 buried 0", fb[0], 1); chk("R8 buried 1", fb[1], 1);
    sum_t = 0; clear_both();
  endtask

  task automatic t_preload();
    pclk_sel = 2'b11; out_inv = 1; preload_en = 1;
    preload_sel = 0; pin_i = 1; pulse_pin();
    chk("R12 into reg0", fb[0], 1); chk("R12 reg1 held", fb[1], 0);
    preload_sel = 1; pin_i = 1; pulse_pin();
    chk("R12 into reg1", fb[1], 1); chk("R12 reg0 held", fb[0], 1);
    preload_sel = 0; pin_i = 0; sync_preset = 1; pulse_pin();
    chk("R12 over preset", fb[0], 0); chk("R12 no preset", fb[1], 1);
    sync_preset = 0; preload_en = 0; out_inv = 0; pclk_sel = 0; pin_i = 0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    t_reset();
    t_dmode();
    t_level();
    t_toggle();
    t_pinclk();
    clear_both(); sum_t[1] = 1; pulse_term(1); sum_t[1] = 0; pulse_term(0);
    t_preset();
    t_clear();
    t_outmodes();
    t_oe();
    t_buried();
    t_preload();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule